// File: doc/BRIEF.md
# UART Receive Queue with Threshold Events and Hardware Flow Control

This block sits between a UART receive shifter and whatever drains received characters, either a DMA channel or a processor. Each character that the shifter presents with a valid strobe goes into a 16-entry first-in first-out queue. The consumer removes the oldest character with a read strobe. The queue shows the oldest character on its read port at all times, so no read request cycle is needed before the strobe.

The fill level is compared with a threshold that a 2-bit selector chooses. When the level reaches the threshold, the block does three things. It sends one single-cycle pulse on the DMA request line. It reports a level-reached cause for the interrupt. It withdraws its ready-to-send indication to the remote transmitter. The DMA request is a one-shot edge and not a level: a consumer that misses or delays the pulse gets no second one while the level stays high. A character-time tick drives an idle watchdog, which signals the same request line for a partially filled queue that has gone quiet.

Top module: `uart_rxq_ctrl`

## Requirements
- R1: The threshold selector `thr_sel` maps 0, 1, 2 and 3 to 1, 4, 8 and 14 bytes. `dma_evt` goes high for exactly one cycle, on the clock edge that follows the edge on which `fill_lvl` first becomes equal to or greater than the threshold.
- R2: No new `dma_evt` pulse is produced while `fill_lvl` stays at or above the threshold, even when more bytes arrive. Once the level falls below the threshold, the next rise to it produces a new pulse.
- R3: Bytes leave in the order they arrived. `rd_data` shows the oldest stored byte. A `rd_stb` in a cycle in which the queue is empty changes nothing.
- R4: A byte offered while `fill_lvl` is 16 is discarded, leaving the stored bytes unchanged. The byte also sets `ovr_flag`, which stays set until reset.
- R5: `rts` (1 = remote may send) goes low one edge after the level reaches the threshold. For selector values 0, 1 and 2 it stays low until the queue is completely empty.
- R6: For selector value 3, `rts` returns high one edge after the level drops below 14.
- R7: When the queue is non-empty and four `char_tick` pulses pass with no byte accepted and no byte read, `dma_evt` pulses once and `irq_id` becomes 2 (idle timeout). Further ticks produce no new pulse. A read or a write clears the condition and restarts the count.
- R8: `irq_id` reads 1 while the level is at or above the threshold, which takes priority. It reads 2 during an idle timeout and 0 otherwise. `rx_irq` equals `rdi_en` AND (`irq_id` ≠ 0).
- R9: After reset the queue is empty, `rts` is 1, and `dma_evt`, `rx_irq`, `irq_id` and `ovr_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_data | input | 8 | Received byte |
| rd_stb | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| thr_sel | input | 2 | Threshold selector (1/4/8/14 bytes) |
| rdi_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One pulse per character time |
| fill_lvl | output | 5 | Number of stored bytes |
| dma_evt | output | 1 | Single-cycle DMA request |
| rx_irq | output | 1 | Level interrupt |
| irq_id | output | 2 | Interrupt cause: 0 none, 1 level, 2 timeout |
| rts | output | 1 | Ready-to-send to the remote transmitter |
| ovr_flag | output | 1 | Sticky overrun |

## Verification
The bench uses the default parameters: a depth of 16 and a timeout of four character times. Because the depth is 16, every selectable threshold can be reached, including 14. That makes the 14-byte hysteresis exception and an overrun at a completely full queue testable at the ports. The table walk holds the 4-byte threshold and covers the one-shot request, its re-arm and the drain-to-empty rule. The directed tests sweep all four selector values and exercise the idle timeout.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_LEVEL = 2'b01,
        CAUSE_IDLE  = 2'b10
    } rxq_cause_e;

    function automatic int unsigned thr_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovr
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;
    logic full;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        st_d    = st_q;
        if (push_ok)
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop_ok)
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push && full)
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= push_data;
    end

    assign head = mem[st_q.rd];
    assign cnt  = st_q.cnt;
    assign ovr  = st_q.ovr;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (st_q.cnt == '0));
    // R4
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> st_q.ovr);
    // R4
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (st_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    sel,
    output logic          thr_pulse,
    output logic          lvl_hit,
    output logic          rts
);
    import rxq_pkg::*;

    typedef struct packed {
        logic armed;
        logic pulse;
        logic rts;
    } st_t;

    st_t st_d, st_q;
    logic is_empty;

    always_comb begin
        lvl_hit  = (cnt >= CW'(thr_bytes(sel)));
        is_empty = (cnt == '0);
        st_d.armed = !lvl_hit;
        st_d.pulse = st_q.armed && lvl_hit;
        if (lvl_hit)
            st_d.rts = 1'b0;
        else if (sel == 2'd3)
            st_d.rts = 1'b1;
        else
            st_d.rts = is_empty ? 1'b1 : st_q.rts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, pulse: 1'b0, rts: 1'b1};
        else        st_q <= st_d;
    end

    assign thr_pulse = st_q.pulse;
    assign rts       = st_q.rts;

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    // R5
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 2'd3 && !st_q.rts && cnt != '0 && $stable(sel)) |=> !st_q.rts);
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
    parameter int TMO_CHARS = 4,
    localparam int TW = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic activity,
    input  logic empty,
    output logic tmo_pulse,
    output logic tmo_pend
);
    typedef struct packed {
        logic [TW-1:0] tcnt;
        logic          pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (activity || empty)
            st_d.tcnt = '0;
        else if (tick && st_q.tcnt != TW'(TMO_CHARS))
            st_d.tcnt = st_q.tcnt + 1'b1;
        st_d.pulse = (st_d.tcnt == TW'(TMO_CHARS)) && (st_q.tcnt != TW'(TMO_CHARS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_pulse = st_q.pulse;
    assign tmo_pend  = (st_q.tcnt == TW'(TMO_CHARS));

    // R7
    tmo_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    // R7
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !tmo_pend);
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
    parameter int DW        = 8,
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    input  logic [1:0]    thr_sel,
    input  logic          rdi_en,
    input  logic          char_tick,
    output logic [CW-1:0] fill_lvl,
    output logic          dma_evt,
    output logic          rx_irq,
    output logic [1:0]    irq_id,
    output logic          rts,
    output logic          ovr_flag
);
    import rxq_pkg::*;

    logic empty, push_ok, pop_ok;
    logic thr_pulse, lvl_hit, tmo_pulse, tmo_pend;
    rxq_cause_e cause;

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_data), .pop(rd_stb),
        .head(rd_data), .cnt(fill_lvl), .empty(empty),
        .push_ok(push_ok), .pop_ok(pop_ok), .ovr(ovr_flag)
    );

    rxq_trigger #(.CW(CW)) u_trig (
        .clk(clk), .rst_n(rst_n), .cnt(fill_lvl), .sel(thr_sel),
        .thr_pulse(thr_pulse), .lvl_hit(lvl_hit), .rts(rts)
    );

    rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick(char_tick),
        .activity(push_ok || pop_ok), .empty(empty),
        .tmo_pulse(tmo_pulse), .tmo_pend(tmo_pend)
    );

    always_comb begin
        if (lvl_hit)       cause = CAUSE_LEVEL;
        else if (tmo_pend) cause = CAUSE_IDLE;
        else               cause = CAUSE_NONE;
    end

    assign irq_id  = cause;
    assign rx_irq  = rdi_en && (cause != CAUSE_NONE);
    assign dma_evt = thr_pulse || tmo_pulse;

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == '0) |-> (irq_id == CAUSE_NONE));
endmodule

// File: tb/uart_rxq_ctrl_test.sv
module uart_rxq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] thr_sel = 2'd1;
    logic rdi_en = 1'b0;
    logic char_tick = 1'b0;
    logic [4:0] fill_lvl;
    logic dma_evt, rx_irq, rts, ovr_flag;
    logic [1:0] irq_id;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rxq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .thr_sel(thr_sel), .rdi_en(rdi_en),
        .char_tick(char_tick), .fill_lvl(fill_lvl), .dma_evt(dma_evt),
        .rx_irq(rx_irq), .irq_id(irq_id), .rts(rts), .ovr_flag(ovr_flag)
    );

    // op[16:15] (0 push, 1 pop), data[14:7], level[6:2], rts[1], evt[0]
    localparam logic [16:0] VEC [13] = '{
        {2'd0, 8'hA0, 5'd1, 1'b1, 1'b0},
        {2'd0, 8'hA1, 5'd2, 1'b1, 1'b0},
        {2'd0, 8'hA2, 5'd3, 1'b1, 1'b0},
        {2'd0, 8'hA3, 5'd4, 1'b0, 1'b1},
        {2'd0, 8'hA4, 5'd5, 1'b0, 1'b0},
        {2'd1, 8'h00, 5'd4, 1'b0, 1'b0},
        {2'd1, 8'h00, 5'd3, 1'b0, 1'b0},
        {2'd0, 8'hA5, 5'd4, 1'b0, 1'b1},
        {2'd1, 8'h00, 5'd3, 1'b0, 1'b0},
        {2'd1, 8'h00, 5'd2, 1'b0, 1'b0},
        {2'd1, 8'h00, 5'd1, 1'b0, 1'b0},
        {2'd1, 8'h00, 5'd0, 1'b1, 1'b0},
        {2'd1, 8'h00, 5'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        rx_valid = 1'b1;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick();
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 fill", int'(fill_lvl), 0);
        chk("R9 rts", int'(rts), 1);
        chk("R9 evt", int'(dma_evt), 0);
        chk("R9 irq", int'(rx_irq), 0);
        chk("R9 id", int'(irq_id), 0);
        chk("R9 ovr", int'(ovr_flag), 0);

        // table walk, threshold 4: R1 R2 R3 R5
        thr_sel = 2'd1;
        for (int i = 0; i < 13; i++) begin
            if (VEC[i][16:15] == 2'd0) push(VEC[i][14:7]);
            else pop();
            chk("R2/R5 vec level", int'(fill_lvl), int'(VEC[i][6:2]));
            chk("R5 vec rts", int'(rts), int'(VEC[i][1]));
            chk("R2 vec evt", int'(dma_evt), int'(VEC[i][0]));
        end

        // R3 ordering
        push(8'h11); push(8'h22); push(8'h33);
        chk("R3 head", int'(rd_data), 8'h11); pop();
        chk("R3 head", int'(rd_data), 8'h22); pop();
        chk("R3 head", int'(rd_data), 8'h33); pop();
        chk("R3 empty", int'(fill_lvl), 0);

        // R1 all thresholds, R5 and R6 RTS release
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr_sel = 2'(s);
            thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            for (int k = 1; k <= thr; k++) begin
                push(8'(k));
                chk("R1 evt at level", int'(dma_evt), (k == thr) ? 1 : 0);
            end
            @(negedge clk);
            chk("R1 pulse width", int'(dma_evt), 0);
            chk("R5 rts low", int'(rts), 0);
            if (s == 3) begin
                pop();
                chk("R6 rts below 14", int'(rts), 1);
                while (fill_lvl != 0) pop();
            end else begin
                for (int k = 1; k < thr; k++) pop();
                chk("R5 rts held", int'(rts), (thr == 1) ? 0 : 0);
                pop();
                chk("R5 rts on empty", int'(rts), 1);
            end
        end

        // R4 overrun
        thr_sel = 2'd3;
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        chk("R4 ovr before", int'(ovr_flag), 0);
        push(8'hEE);
        chk("R4 level", int'(fill_lvl), 16);
        chk("R4 ovr set", int'(ovr_flag), 1);
        for (int i = 0; i < 16; i++) begin
            chk("R4 data kept", int'(rd_data), 8'h40 + i);
            pop();
        end
        chk("R4 ovr sticky", int'(ovr_flag), 1);

        // R8 interrupt enable and cause
        thr_sel = 2'd0;
        rdi_en = 1'b0;
        push(8'h55);
        chk("R8 id level", int'(irq_id), 1);
        chk("R8 irq masked", int'(rx_irq), 0);
        rdi_en = 1'b1;
        @(negedge clk);
        chk("R8 irq on", int'(rx_irq), 1);
        pop();
        chk("R8 id none", int'(irq_id), 0);
        chk("R8 irq off", int'(rx_irq), 0);

        // R7 idle timeout
        thr_sel = 2'd3;
        push(8'h01); push(8'h02);
        for (int t = 1; t <= 3; t++) begin
            tick();
            chk("R7 early", int'(dma_evt), 0);
        end
        tick();
        chk("R7 fire", int'(dma_evt), 1);
        chk("R7 id", int'(irq_id), 2);
        chk("R7 irq", int'(rx_irq), 1);
        @(negedge clk);
        chk("R7 one cycle", int'(dma_evt), 0);
        for (int t = 0; t < 4; t++) begin
            tick();
            chk("R7 no repeat", int'(dma_evt), 0);
        end
        pop();
        chk("R7 cleared", int'(irq_id), 0);
        for (int t = 1; t <= 4; t++) begin
            tick();
            chk("R7 restart", int'(dma_evt), (t == 4) ? 1 : 0);
        end
        pop();
        for (int t = 0; t < 5; t++) begin
            tick();
            chk("R7 empty quiet", int'(dma_evt), 0);
        end
        chk("R7 empty id", int'(irq_id), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule